// File: doc/BRIEF.md
# Bidirectional Parallel Port Controller

This block manages an eight-pin bidirectional port as seen by a processor on a small register bus. Each pin has a direction bit and a data bit, and software sets both. From these two bits the block works out three pad controls for each pin: an output enable, the level to drive, and a weak pull-up request. One chip-level input forces every pull-up off at once.

The external pin levels reach software through a two-stage capture. A level-sensitive stage is open while the clock is low. A rising-edge register follows it. Software reads the captured levels at a third address. The levels are captured whatever the direction bit is, so a pin that is being driven reads back its own level. That address cannot be written. Instead, writing a one to any of its bits inverts the matching data bit, and bits written as zero are left alone.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), every direction and data bit is 0, and all `pad_oe` and `pad_pu` bits are 0.
- R2: With `bus_wr` high at a rising edge, address 0 loads the direction byte and address 1 loads the data byte. With `bus_rd` high, address 0 and address 1 return the stored bytes on `bus_rdata`.
- R3: A write to address 2 inverts every data bit whose `bus_wdata` bit is 1 and leaves the other data bits unchanged. This happens whatever the direction bits are.
- R4: A pin with direction 0 and data 0 has `pad_oe`=0, `pad_pu`=0 and `pad_out`=0.
- R5: A pin with direction 0 and data 1 has `pad_oe`=0 and `pad_pu` equal to the inverse of `pud_all`. While `pud_all` is 1, no `pad_pu` bit is 1.
- R6: A pin with direction 1 has `pad_oe`=1, `pad_out` equal to its data bit, and `pad_pu`=0.
- R7: A read of address 2 returns `pin_in` as captured at the most recent rising edge through a stage that is open while `clk` is low. A change made while `clk` is low appears after the next rising edge. A change made while `clk` is high appears only after the rising edge after that.
- R8: The pin capture does not depend on direction. An output pin whose pad is looped back reads its own driven level at address 2.
- R9: A write to address 3 changes nothing, and a read of address 3 returns 0. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 data, 2 pin capture, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data (combinational, 0 when not reading) |
| pud_all | input | 1 | Global pull-up disable |
| pin_in | input | 8 | External pin levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin drive level |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The checker covers the following on every cycle:
- the pull-up and output enable of a pin are never both on;
- `pud_all` suppresses every pull-up;
- a toggle write inverts exactly the data bits selected by its mask;
- writes to the unused address leave the stored state alone;
- the read mux and the idle read value are correct;
- the state is cleared after reset.

The half-cycle capture latency can only be shown by the bench scenarios. Those scenarios change `pin_in` in the low phase of the clock and in the high phase, and check the read value before and after each edge. The same holds for loopback readback and for the full mapping from direction, data and `pud_all` to the pad outputs under random stimulus.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned PORT_W = 8;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pad_ctl_t;

    function automatic pad_ctl_t pad_decode(input logic dir, input logic dat, input logic pud);
        pad_ctl_t c;
        c.oe  = dir;
        c.out = dir & dat;
        c.pu  = ~dir & dat & ~pud;
        return c;
    endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  reg_sel_e            wr_sel,
    input  logic [W-1:0]        wr_data,
    output logic [W-1:0]        dir_q,
    output logic [W-1:0]        data_q
);
    logic [W-1:0] dir_d, data_d;

    always_comb begin
        dir_d  = dir_q;
        data_d = data_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_DIR:  dir_d  = wr_data;
                SEL_DATA: data_d = wr_data;
                SEL_PIN:  data_d = data_q ^ wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            data_q <= '0;
        end else begin
            dir_q  <= dir_d;
            data_q <= data_d;
        end
    end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_sync
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic lat_q;

        always_latch begin
            if (!clk) lat_q <= pin_raw[b];
        end

        always_ff @(posedge clk) begin
            if (rst) pin_sync[b] <= 1'b0;
            else     pin_sync[b] <= lat_q;
        end
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] dat,
    input  logic         pud,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] pu
);
    for (genvar b = 0; b < W; b++) begin : g_pad
        pad_ctl_t ctl;
        always_comb begin
            ctl    = pad_decode(dir[b], dat[b], pud);
            oe[b]  = ctl.oe;
            out[b] = ctl.out;
            pu[b]  = ctl.pu;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [W-1:0]       bus_wdata,
    input  logic               bus_rd,
    output logic [W-1:0]       bus_rdata,
    input  logic               pud_all,
    input  logic [W-1:0]       pin_in,
    output logic [W-1:0]       pad_oe,
    output logic [W-1:0]       pad_out,
    output logic [W-1:0]       pad_pu
);
    reg_sel_e     sel;
    logic [W-1:0] dir_q, data_q, pin_q;

    assign sel = reg_sel_e'(bus_addr);

    gpio_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .wr_sel  (sel),
        .wr_data (bus_wdata),
        .dir_q   (dir_q),
        .data_q  (data_q)
    );

    gpio_pin_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_raw  (pin_in),
        .pin_sync (pin_q)
    );

    gpio_pad_ctrl #(.W(W)) u_pad (
        .dir (dir_q),
        .dat (data_q),
        .pud (pud_all),
        .oe  (pad_oe),
        .out (pad_out),
        .pu  (pad_pu)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_DIR:  bus_rdata = dir_q;
                SEL_DATA: bus_rdata = data_q;
                SEL_PIN:  bus_rdata = pin_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   bus_addr,
    input logic         bus_wr,
    input logic [W-1:0] bus_wdata,
    input logic         bus_rd,
    input logic [W-1:0] bus_rdata,
    input logic         pud_all,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] data_q,
    input logic [W-1:0] pin_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (dir_q == '0 && data_q == '0));

    assert_toggle_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2) |=> data_q == ($past(data_q) ^ $past(bus_wdata)));

    assert_pud_kills_pu_R5: assert property (@(posedge clk) disable iff (rst)
        pud_all |-> pad_pu == '0);

    assert_pu_vs_oe_R6: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_oe) == '0);

    assert_pin_read_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd2) |-> bus_rdata == pin_q);

    assert_unused_wr_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3) |=> ($stable(dir_q) && $stable(data_q)));

    assert_idle_read_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == '0);
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pud_all   (pud_all),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .pin_q     (pin_q)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic         bus_rd = 1'b0;
    logic [W-1:0] bus_rdata;
    logic         pud_all = 1'b0;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pad_oe, pad_out, pad_pu;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [W-1:0] m_dir = '0, m_dat = '0;

    always #4 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pud_all(pud_all), .pin_in(pin_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu)
    );

    function automatic logic [W-1:0] exp_oe(input logic [W-1:0] d);
        return d;
    endfunction
    function automatic logic [W-1:0] exp_out(input logic [W-1:0] d, input logic [W-1:0] v);
        return d & v;
    endfunction
    function automatic logic [W-1:0] exp_pu(input logic [W-1:0] d, input logic [W-1:0] v, input logic p);
        return p ? '0 : (~d & v);
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd0) m_dir = d;
        else if (a == 2'd1) m_dat = d;
        else if (a == 2'd2) m_dat = m_dat ^ d;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic chk_pads(input string req);
        chk({req, " oe"},  pad_oe,  exp_oe(m_dir));
        chk({req, " out"}, pad_out, exp_out(m_dir, m_dat));
        chk({req, " pu"},  pad_pu,  exp_pu(m_dir, m_dat, pud_all));
    endtask

    initial begin
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", pad_oe, '0);
        chk("R1 pu", pad_pu, '0);
        rd(2'd1, v); chk("R1 data", v, '0);
        rd(2'd0, v); chk("R1 dir", v, '0);
        chk("R9 idle rdata", bus_rdata, '0);

        // R2 store and read back
        wr(2'd0, 8'h3C); rd(2'd0, v); chk("R2 dir", v, 8'h3C);
        wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 data", v, 8'hA5);
        chk_pads("R6");

        // R4/R5 input configurations, pull-up disable
        wr(2'd0, 8'h00); wr(2'd1, 8'h0F);
        pud_all = 1'b0; #1 chk_pads("R5 pu on");
        chk("R4 hi-z pins", pad_pu & 8'hF0, 8'h00);
        pud_all = 1'b1; #1 chk("R5 pud", pad_pu, 8'h00);
        pud_all = 1'b0;

        // R3 toggle, independent of direction
        wr(2'd0, 8'hF0); wr(2'd1, 8'h33);
        wr(2'd2, 8'h81); rd(2'd1, v); chk("R3 toggle", v, 8'hB2);
        wr(2'd2, 8'h00); rd(2'd1, v); chk("R3 zero mask", v, 8'hB2);
        chk_pads("R3 pads");

        // R9 unused address
        wr(2'd3, 8'hFF); rd(2'd1, v); chk("R9 data kept", v, 8'hB2);
        rd(2'd0, v); chk("R9 dir kept", v, 8'hF0);
        rd(2'd3, v); chk("R9 read 3", v, 8'h00);

        // R7 capture latency, change during low phase
        @(negedge clk); pin_in = 8'h5A;
        rd(2'd2, v); chk("R7 before edge", v, 8'h00);
        @(negedge clk); rd(2'd2, v); chk("R7 after edge", v, 8'h5A);
        // change during high phase
        @(posedge clk); #1 pin_in = 8'hC3;
        @(negedge clk); rd(2'd2, v); chk("R7 high-phase hold", v, 8'h5A);
        @(negedge clk); rd(2'd2, v); chk("R7 high-phase late", v, 8'hC3);

        // R8 loopback of driven output
        wr(2'd0, 8'hFF); wr(2'd1, 8'h96);
        pin_in = pad_out;
        @(negedge clk); rd(2'd2, v); chk("R8 loopback", v, 8'h96);

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [1:0] a;
            logic [W-1:0] d;
            a = 2'($urandom % 4);
            d = 8'($urandom);
            wr(a, d);
            pud_all = 1'($urandom);
            pin_in = 8'($urandom);
            #1 chk_pads("R4/R5/R6 random");
            @(negedge clk);
            rd(2'd2, v); chk("R7 random", v, pin_in);
            rd(2'd1, v); chk("R2/R3 random", v, m_dat);
        end

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; m_dir = '0; m_dat = '0;
        #1 chk_pads("R1 rerst");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #(8 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule